// File: doc/BRIEF.md
# Micro-frame Index and Lagged Start-of-Frame Number Generator

This block holds the host controller's micro-frame counter. The counter is the index into the periodic frame list. The block also derives the 11-bit frame number that goes into each start-of-frame token. The low three bits of the index count the eight micro-frames in a 1 ms frame. The bits above them select the frame-list entry.

The frame number sent on the bus is a separate register, not a slice of the index. It always trails the index by one micro-frame. When the index enters micro-frame 0 of frame N, the bus still announces frame N-1. It moves to N only at the next micro-frame. As a result, the host's schedule boundary sits one micro-frame ahead of the bus boundary, and the schedule never has to handle a frame-wrap case at its own edges.

Each micro-frame tick advances the index while the controller runs, and each such tick also produces one start-of-frame strobe. While the controller is stopped, software may load a new index. The lagged frame number then follows, set to one micro-frame before the loaded value.

Top module: `uframe_sof_gen`

## Requirements
- R1: After reset, idx_o is 0, uframe_o is 0 and sof_frame_o is 2047, which is the frame of the micro-frame just before index 0. sof_stb_o and roll_o are low.
- R2: A cycle with run_i high and utick_i high adds one to idx_o, modulo 2^14, at the next clock edge. uframe_o always equals idx_o[2:0].
- R3: While run_i is low, utick_i has no effect: idx_o and sof_frame_o hold and no strobe is produced.
- R4: Each tick taken while running raises sof_stb_o for exactly one cycle, in the cycle in which the new index is visible. With no tick, the strobe is low.
- R5: sof_frame_o always equals ((idx_o - 1) mod 2^14) >> 3. The frame number therefore changes when uframe_o goes from 0 to 1, not from 7 to 0.
- R6: The index wraps from 16383 to 0. The frame number reaches 0 one tick later, after showing 2047 while idx_o is 0.
- R7: roll_o pulses for one cycle, together with the new index, whenever an advance toggles idx_o[13] (8191 to 8192 and 16383 to 0). On all other advances it stays low.
- R8: While run_i is low, a cycle with idx_wr_i high loads idx_wdata_i into idx_o at the next edge. sof_frame_o becomes ((idx_wdata_i - 1) mod 2^14) >> 3, and neither sof_stb_o nor roll_o pulses.
- R9: While run_i is high, idx_wr_i is ignored and idx_o keeps counting only on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Controller running; enables advancing, blocks loads |
| utick_i | input | 1 | One-cycle pulse at every 125 us micro-frame boundary |
| idx_wr_i | input | 1 | Software load strobe for the index |
| idx_wdata_i | input | 14 | Value to load into the index |
| idx_o | output | 14 | Frame-list index (micro-frame counter) |
| uframe_o | output | 3 | Current micro-frame number within the frame |
| sof_frame_o | output | 11 | Lagged frame number for the start-of-frame token |
| sof_stb_o | output | 1 | One-cycle strobe to emit a start-of-frame token |
| roll_o | output | 1 | One-cycle pulse when the index's top bit toggles |

## Verification
The hardest behaviour to reach from the ports is the pair of wrap events. The top-bit rollover and the 2047-to-0 frame wrap lie thousands of ticks away from reset. The bench reaches both by stopping the controller, loading an index a few micro-frames before 8192 or before 16383, and then running. Loading an index of 0 is a further case: it checks that the lagged value is correctly initialised to frame 2047 across the index wrap.

// File: rtl/sofgen_pkg.sv
package sofgen_pkg;
  localparam int unsigned IDX_W_DEF = 14;
  localparam int unsigned UF_W_DEF  = 3;

  typedef struct packed {
    logic adv;
    logic load;
  } sof_evt_t;
endpackage

// File: rtl/sofgen_index.sv
module sofgen_index
  import sofgen_pkg::*;
#(
  parameter int unsigned IDX_W = IDX_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sof_evt_t         ev_i,
  input  logic [IDX_W-1:0] wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             wrap_o
);
  localparam int unsigned MSB = IDX_W - 1;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] v);
    return v + IDX_W'(1);
  endfunction

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nxt;
  logic             wrap_q;
  logic             top_flip;

  assign idx_nxt  = step_idx(idx_q);
  assign top_flip = idx_nxt[MSB] ^ idx_q[MSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (ev_i.load) begin
        idx_q <= wdata_i;
      end else if (ev_i.adv) begin
        idx_q  <= idx_nxt;
        wrap_q <= top_flip;
      end
    end
  end

  assign idx_o  = idx_q;
  assign wrap_o = wrap_q;

  // R2: an advance moves the index by exactly one
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.adv |=> idx_o == IDX_W'($past(idx_o) + IDX_W'(1)));

  // R7: a rollover pulse only accompanies a change of the top bit
  p_roll_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> idx_o[MSB] != $past(idx_o[MSB]));

  // R8: a load takes the written value
  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.load |=> idx_o == $past(wdata_i));
endmodule

// File: rtl/sofgen_lag.sv
module sofgen_lag
  import sofgen_pkg::*;
#(
  parameter int unsigned IDX_W = IDX_W_DEF,
  parameter int unsigned UF_W  = UF_W_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  sof_evt_t              ev_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [IDX_W-1:0]      wdata_i,
  output logic [IDX_W-UF_W-1:0] frame_o,
  output logic                  stb_o
);
  localparam int unsigned FR_W = IDX_W - UF_W;

  function automatic logic [IDX_W-1:0] prior_uframe(input logic [IDX_W-1:0] v);
    return v - IDX_W'(1);
  endfunction

  logic [IDX_W-1:0] lag_q;
  logic             stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lag_q <= prior_uframe('0);
      stb_q <= 1'b0;
    end else begin
      stb_q <= ev_i.adv;
      if (ev_i.load) begin
        lag_q <= prior_uframe(wdata_i);
      end else if (ev_i.adv) begin
        lag_q <= idx_i;
      end
    end
  end

  assign frame_o = lag_q[IDX_W-1 -: FR_W];
  assign stb_o   = stb_q;

  // R4: every advance yields a strobe on the next cycle
  p_stb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.adv |=> stb_o);

  // R4: no strobe without a preceding advance
  p_nostb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i.adv |=> !stb_o);
endmodule

// File: rtl/uframe_sof_gen.sv
module uframe_sof_gen
  import sofgen_pkg::*;
#(
  parameter int unsigned IDX_W = IDX_W_DEF,
  parameter int unsigned UF_W  = UF_W_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic                  utick_i,
  input  logic                  idx_wr_i,
  input  logic [IDX_W-1:0]      idx_wdata_i,
  output logic [IDX_W-1:0]      idx_o,
  output logic [UF_W-1:0]       uframe_o,
  output logic [IDX_W-UF_W-1:0] sof_frame_o,
  output logic                  sof_stb_o,
  output logic                  roll_o
);
  localparam int unsigned FR_W = IDX_W - UF_W;

  function automatic logic [FR_W-1:0] bus_frame_of(input logic [IDX_W-1:0] v);
    logic [IDX_W-1:0] back;
    back = v - IDX_W'(1);
    return back[IDX_W-1 -: FR_W];
  endfunction

  sof_evt_t ev;
  logic     adv_evt;
  logic     load_evt;

  assign adv_evt  = run_i & utick_i;
  assign load_evt = idx_wr_i & ~run_i;
  assign ev.adv   = adv_evt;
  assign ev.load  = load_evt;

  logic [IDX_W-1:0] idx_w;
  logic             wrap_w;

  sofgen_index #(.IDX_W(IDX_W)) u_index (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .wdata_i (idx_wdata_i),
    .idx_o   (idx_w),
    .wrap_o  (wrap_w)
  );

  sofgen_lag #(.IDX_W(IDX_W), .UF_W(UF_W)) u_lag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .idx_i   (idx_w),
    .wdata_i (idx_wdata_i),
    .frame_o (sof_frame_o),
    .stb_o   (sof_stb_o)
  );

  assign idx_o    = idx_w;
  assign uframe_o = idx_w[UF_W-1:0];
  assign roll_o   = wrap_w;

  // R5: lagged frame register stays one micro-frame behind the index register
  p_lag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_frame_o == bus_frame_of(idx_o));

  // R3: stopped with no load leaves index and strobe idle
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !idx_wr_i) |=> ($stable(idx_o) && !sof_stb_o));

  // R9: a write while running without a tick changes nothing
  p_ignore_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && idx_wr_i && !utick_i) |=> $stable(idx_o));

  // R8: loads never raise the strobe or the rollover flag
  p_load_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_evt |=> (!sof_stb_o && !roll_o));
endmodule

// File: tb/uframe_sof_gen_tb_top.sv
module uframe_sof_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic [13:0] wdata = '0;
  logic [13:0] idx;
  logic [2:0]  uf;
  logic [10:0] sof;
  logic        stb;
  logic        roll;

  int checks = 0;
  int errors = 0;
  int exp_idx = 0;

  always #5 clk = ~clk;

  uframe_sof_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .utick_i(tick),
    .idx_wr_i(wr), .idx_wdata_i(wdata), .idx_o(idx), .uframe_o(uf),
    .sof_frame_o(sof), .sof_stb_o(stb), .roll_o(roll)
  );

  function automatic int lag_frame(input int v);
    return ((v + 16383) % 16384) / 8;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(idx == 14'(exp_idx), {req, " index"}, idx, exp_idx);
    chk(uf == 3'(exp_idx % 8), "R2 uframe", uf, exp_idx % 8);
    chk(sof == 11'(lag_frame(exp_idx)), "R5 sof frame", sof, lag_frame(exp_idx));
  endtask

  // one tick cycle, then one idle cycle
  task automatic do_tick();
    int prev;
    bit exp_roll;
    prev = exp_idx;
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1;
    tick = 1'b0;
    if (run) exp_idx = (exp_idx + 1) % 16384;
    exp_roll = run && ((prev / 8192) != (exp_idx / 8192));
    check_state(run ? "R2" : "R3");
    chk(stb == run, "R4 strobe on tick", stb, run);
    chk(roll == exp_roll, "R7 rollover", roll, exp_roll);
    @(posedge clk); #1;
    chk(stb == 1'b0, "R4 strobe width", stb, 0);
    chk(roll == 1'b0, "R7 rollover width", roll, 0);
  endtask

  task automatic do_load(input int v);
    @(negedge clk); wr = 1'b1; wdata = 14'(v);
    @(posedge clk); #1;
    wr = 1'b0;
    if (!run) exp_idx = v;
    check_state(run ? "R9" : "R8");
    chk(stb == 1'b0 && roll == 1'b0, "R8 quiet load", {stb, roll}, 0);
  endtask

  task automatic t_reset();
    check_state("R1");
    chk(sof == 11'd2047, "R1 sof at reset", sof, 2047);
    chk(stb == 1'b0 && roll == 1'b0, "R1 flags at reset", {stb, roll}, 0);
  endtask

  task automatic t_count();
    run = 1'b1;
    for (int i = 0; i < 12; i++) begin
      do_tick();
      if (exp_idx == 1) chk(sof == 11'd0, "R5 sof moves at uframe 1", sof, 0);
      if (exp_idx == 8) chk(sof == 11'd0, "R5 sof holds at uframe 0", sof, 0);
      if (exp_idx == 9) chk(sof == 11'd1, "R5 sof steps at uframe 1", sof, 1);
    end
  endtask

  task automatic t_stopped();
    run = 1'b0;
    for (int i = 0; i < 3; i++) do_tick();
  endtask

  task automatic t_load_wraps();
    run = 1'b0;
    do_load(0);
    chk(sof == 11'd2047, "R8 load zero gives 2047", sof, 2047);
    do_load(8189);
    run = 1'b1;
    for (int i = 0; i < 5; i++) do_tick();
    run = 1'b0;
    do_load(16381);
    chk(sof == 11'd2047, "R8 lag after load", sof, 2047);
    run = 1'b1;
    for (int i = 0; i < 4; i++) begin
      do_tick();
      if (exp_idx == 0) chk(sof == 11'd2047, "R6 sof still 2047 at index 0", sof, 2047);
      if (exp_idx == 1) chk(sof == 11'd0, "R6 sof wraps to 0", sof, 0);
    end
  endtask

  task automatic t_load_running();
    run = 1'b1;
    do_load(100);
    do_tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_count();
    t_stopped();
    t_load_wraps();
    t_load_running();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule